// File: doc/BRIEF.md
# Conditional Commit Gate

This block sits between an ALU and the register file of a small processor. For each executed instruction it looks at a 3-bit condition code and the five stored flags. From these it decides two things: whether the ALU result is written to the destination register, and whether the fresh ALU flags replace the stored ones. It holds the flags itself, Zero, Sign, Carry, Propagate and Generate, and shows them as the low bits of an 8-bit status byte.

A special "never" code still lets the instruction update the flags while it blocks the register write. This gives compare and test operations without needing dedicated opcodes. A condition is always judged against the flags as they stood before the instruction. Any flag update lands on the clock edge of the execute strobe.

Top module: `cond_commit_gate`

## Requirements
- R1: With condition code 3'b000 (always), `destWe` is high whenever `execStb` is high.
- R2: Code 3'b001 passes when Z (stored bit 0) is 1. Code 3'b010 passes when S (bit 1) is 1. Code 3'b011 passes when C (bit 2) is 1. A passing code drives `destWe` high during `execStb`.
- R3: Code 3'b101 passes when Z is 0. Code 3'b110 passes when C is 0. Code 3'b111 passes when S is 0.
- R4: Code 3'b100 (never) keeps `destWe` low. It still loads `aluFlags` into the stored flags when `setFlags` is high on a strobed cycle.
- R5: `statusFlags` bits are Z at 0, S at 1, C at 2, P at 3 and G at 4. Bits 7..5 read 0. `aluFlags` uses the same bit order in bits 4..0.
- R6: The stored flags load `aluFlags` only on a clock edge where `execStb` and `setFlags` are both high and the condition passes or is never.
- R7: The condition is judged against the flags stored before the current edge. A flag update is visible on `statusFlags` after that edge.
- R8: When a code other than never fails, `destWe` stays low and the stored flags keep their value.
- R9: While `rstN` is low, all five flags are cleared.
- R10: `destWe` is never high while `execStb` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| execStb | input | 1 | Execute strobe for the current instruction |
| condCode | input | 3 | Condition field of the instruction |
| setFlags | input | 1 | Instruction asks for a flag update |
| aluFlags | input | 5 | Fresh ALU flags {G,P,C,S,Z} |
| destWe | output | 1 | Destination register write enable |
| statusFlags | output | 8 | Stored flags, zero-extended |

## Verification
The bench sweeps every one of the 32 stored-flag states against all eight condition codes and both values of the set-flags bit. For each case it uses fresh ALU flags that are the bitwise inverse of the stored state. Because of this, any load, missed load or partial load shows up in every bit, and a condition judged on the new flags instead of the old ones gives a wrong write enable. Extra cases pulse the condition and flag inputs with the strobe low. These show the strobe gating both outputs, and a reset in the middle of a run shows that all flags clear.

// File: rtl/cond_gate_pkg.sv
package cond_gate_pkg;
  localparam int FLAG_W   = 5;
  localparam int STATUS_W = 8;
  localparam int COND_W   = 3;

  localparam int Z_IDX = 0;
  localparam int S_IDX = 1;
  localparam int C_IDX = 2;

  typedef enum logic [COND_W-1:0] {
    CC_ALWAYS = 3'b000,
    CC_ZSET   = 3'b001,
    CC_SSET   = 3'b010,
    CC_CSET   = 3'b011,
    CC_NEVER  = 3'b100,
    CC_ZCLR   = 3'b101,
    CC_CCLR   = 3'b110,
    CC_SCLR   = 3'b111
  } condCode_e;

  typedef struct packed {
    logic destWrite;
    logic flagLoad;
  } gateCtl_t;
endpackage

// File: rtl/cond_gate_ctrl.sv
module cond_gate_ctrl
  import cond_gate_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              execStb,
  input  logic [COND_W-1:0] condCode,
  input  logic              setFlags,
  input  logic [FLAG_W-1:0] flagQ,
  output gateCtl_t          ctl
);
  logic condPass;
  logic isNever;

  always_comb begin
    condPass = 1'b0;
    unique case (condCode_e'(condCode))
      CC_ALWAYS: condPass = 1'b1;
      CC_ZSET:   condPass = flagQ[Z_IDX];
      CC_SSET:   condPass = flagQ[S_IDX];
      CC_CSET:   condPass = flagQ[C_IDX];
      CC_NEVER:  condPass = 1'b0;
      CC_ZCLR:   condPass = !flagQ[Z_IDX];
      CC_CCLR:   condPass = !flagQ[C_IDX];
      CC_SCLR:   condPass = !flagQ[S_IDX];
      default:   condPass = 1'b0;
    endcase
  end

  assign isNever       = (condCode == CC_NEVER);
  assign ctl.destWrite = execStb && condPass;
  assign ctl.flagLoad  = execStb && setFlags && (condPass || isNever);

  // R4
  never_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (condCode == CC_NEVER) |-> !ctl.destWrite);

  // R10
  write_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.destWrite |-> execStb);

  // R6
  load_needs_setflags_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.flagLoad |-> (setFlags && execStb));
endmodule

// File: rtl/cond_gate_flags.sv
module cond_gate_flags
  import cond_gate_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  gateCtl_t            ctl,
  input  logic [FLAG_W-1:0]   aluFlags,
  output logic [FLAG_W-1:0]   flagQ,
  output logic [STATUS_W-1:0] statusByte
);
  localparam int PAD_W = STATUS_W - FLAG_W;

  always_ff @(posedge clk) begin
    if (!rstN)             flagQ <= '0;
    else if (ctl.flagLoad) flagQ <= aluFlags;
  end

  assign statusByte = {{PAD_W{1'b0}}, flagQ};

  // R8
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.flagLoad |=> $stable(flagQ));

  // R7
  flags_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.flagLoad |=> (flagQ == $past(aluFlags)));
endmodule

// File: rtl/cond_commit_gate.sv
module cond_commit_gate
  import cond_gate_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                execStb,
  input  logic [COND_W-1:0]   condCode,
  input  logic                setFlags,
  input  logic [FLAG_W-1:0]   aluFlags,
  output logic                destWe,
  output logic [STATUS_W-1:0] statusFlags
);
  gateCtl_t          ctl;
  logic [FLAG_W-1:0] flagQ;

  cond_gate_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .execStb(execStb), .condCode(condCode),
    .setFlags(setFlags), .flagQ(flagQ), .ctl(ctl)
  );

  cond_gate_flags flags_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .aluFlags(aluFlags),
    .flagQ(flagQ), .statusByte(statusFlags)
  );

  assign destWe = ctl.destWrite;
endmodule

// File: tb/cond_commit_gate_tb_top.sv
module cond_commit_gate_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       execStb = 1'b0;
  logic [2:0] condCode = 3'b000;
  logic       setFlags = 1'b0;
  logic [4:0] aluFlags = 5'b0;
  logic       destWe;
  logic [7:0] statusFlags;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  cond_commit_gate dut_i (
    .clk(clk), .rstN(rstN), .execStb(execStb), .condCode(condCode),
    .setFlags(setFlags), .aluFlags(aluFlags), .destWe(destWe),
    .statusFlags(statusFlags)
  );

  function automatic bit passes(input logic [2:0] cc, input logic [4:0] f);
    case (cc)
      3'b000: return 1'b1;
      3'b001: return f[0];
      3'b010: return f[1];
      3'b011: return f[2];
      3'b100: return 1'b0;
      3'b101: return !f[0];
      3'b110: return !f[2];
      default: return !f[1];
    endcase
  endfunction

  function automatic string reqOf(input logic [2:0] cc);
    case (cc)
      3'b000: return "R1";
      3'b001, 3'b010, 3'b011: return "R2";
      3'b100: return "R4";
      default: return "R3";
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one strobed instruction; returns after the update edge
  task automatic runOp(input logic [2:0] cc, input bit sf, input logic [4:0] alu,
                       input logic [4:0] pre);
    bit pass = passes(cc, pre);
    logic [4:0] expF;
    @(negedge clk);
    execStb = 1'b1; condCode = cc; setFlags = sf; aluFlags = alu;
    #1;
    check({reqOf(cc), pass ? "" : "/R8"}, {7'b0, destWe}, {7'b0, pass});
    @(posedge clk); #1;
    execStb = 1'b0;
    expF = (sf && (pass || cc == 3'b100)) ? alu : pre;
    check(sf ? "R6/R7" : "R6/R8", statusFlags, {3'b000, expF});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R9", statusFlags, 8'h00);
    check("R10", {7'b0, destWe}, 8'h00);
    rstN = 1'b1;

    for (int f = 0; f < 32; f++) begin
      for (int c = 0; c < 8; c++) begin
        for (int s = 0; s < 2; s++) begin
          // preload stored flags through an always/set instruction (R5 bit order)
          runOp(3'b000, 1'b1, 5'(f), statusFlags[4:0]);
          check("R5", statusFlags, {3'b000, 5'(f)});
          runOp(3'(c), s[0], ~5'(f), 5'(f));
        end
      end
    end

    // strobe low: nothing written, flags untouched (R10)
    runOp(3'b000, 1'b1, 5'h15, statusFlags[4:0]);
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      execStb = 1'b0; condCode = 3'(c); setFlags = 1'b1; aluFlags = 5'h0A;
      #1;
      check("R10", {7'b0, destWe}, 8'h00);
      @(posedge clk); #1;
      check("R10", statusFlags, 8'h15);
    end

    // reset mid-run clears flags (R9)
    @(negedge clk); rstN = 1'b0;
    @(posedge clk); #1;
    check("R9", statusFlags, 8'h00);
    rstN = 1'b1;
    runOp(3'b001, 1'b1, 5'h1F, 5'h00);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule